// File: doc/BRIEF.md
# Banked Scratchpad Conflict Detector

This block inspects one group of parallel memory requests aimed at a 32-bank scratchpad whose banks each supply 64 bits per clock. Every lane of a 32-lane group presents a valid bit and a 16-bit word address (one word is 32 bits). For each lane the block reports the bank the address lands in. For the group as a whole it reports whether any bank has to be visited more than once and how many serialized passes the worst bank needs. A replay scheduler would use these results to decide how to split the access.

A one-bit interleave select picks how addresses spread across the banks. In word-32 interleave (select 0), consecutive 32-bit words go to consecutive banks. In word-64 interleave (select 1), consecutive 64-bit words go to consecutive banks. In both settings a bank row holds 64 bits, which is one 64-word segment of the address space in word-32 interleave. Two requests to one bank share a pass only when they fall in the same row, so in both settings the row is the address shifted right by 6.

A request strobe captures the inputs. The results appear together with a one-cycle done pulse on the following clock, and they hold until the next strobe.

Top module: `bank_conflict_detect`

## Requirements
- R1: With interleave select 0, each lane's bank output (bits [5l+4:5l] of `bank_idx` for lane l) equals address bits [4:0].
- R2: With interleave select 1, each lane's bank output equals address bits [5:1].
- R3: With select 1, two active lanes whose addresses fall in the same bank but in different 64-bit words cause a conflict. Lanes that touch consecutive 64-bit words never conflict.
- R4: With select 0, two active lanes in one bank conflict only when their addresses differ in address >> 6. Addresses i and i+32 inside one 64-word aligned segment do not conflict.
- R5: Lanes whose valid bit is low have no effect on `conflict` or `passes`.
- R6: Active lanes that address the same row of the same bank (including the identical word) are served together and do not cause a conflict.
- R7: `passes` is the largest number of distinct rows that any single bank must serve. It is 1 for a conflict-free group with at least one active lane and 0 when no lane is active. `conflict` is high exactly when `passes` exceeds 1.
- R8: `done` pulses high for exactly the one cycle after a cycle with `req` high. The results change only on that edge and hold while `req` stays low.
- R9: A synchronous reset clears `done`, `conflict`, `passes` and every bank output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Capture strobe for the current group |
| mode | input | 1 | Interleave select: 0 word-32, 1 word-64 |
| lane_valid | input | 32 | Per-lane active bits |
| lane_addr | input | 512 | Per-lane 16-bit word addresses, lane l at bits [16l+15:16l] |
| done | output | 1 | One-cycle pulse when the results are fresh |
| conflict | output | 1 | Some bank needs more than one pass |
| passes | output | 6 | Worst-case pass count over all banks (0 to 32) |
| bank_idx | output | 160 | Per-lane 5-bit bank index, lane l at bits [5l+4:5l] |

## Verification
The bench builds the block with its default parameters: 32 lanes, 32 banks and 16-bit addresses. At this size a stride of 64 words sends all 32 lanes into bank 0 with 32 distinct rows, so the pass counter reaches its full 6-bit range. The 16-bit address also reaches many segments, which allows unaligned runs of 64-bit elements that cross a segment boundary in word-32 interleave but not in word-64 interleave. Mixed groups combine a broadcast, one conflicting row and one masked lane in the same bank to show that only active, distinct rows are counted.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  // Interleave granularity between adjacent banks
  typedef enum logic {
    IL_WORD32 = 1'b0,
    IL_WORD64 = 1'b1
  } interleave_e;
endpackage

// File: rtl/bcd_bank_map.sv
module bcd_bank_map #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 5
) (
  input  logic [ADDR_W-1:0]   addr,
  input  bcd_pkg::interleave_e mode,
  output logic [BANK_W-1:0]   bank,
  output logic [ADDR_W-1:0]   row
);
  import bcd_pkg::*;

  // Bank select: low bits for 32-bit interleave, skip the half-word bit for 64-bit interleave
  function automatic logic [BANK_W-1:0] bank_of(input logic [ADDR_W-1:0] a,
                                                input interleave_e m);
    return (m == IL_WORD64) ? a[BANK_W:1] : a[BANK_W-1:0];
  endfunction

  // A bank row is 64 bits wide: 2*BANKS words share one row index in either mode
  function automatic logic [ADDR_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a >> (BANK_W + 1);
  endfunction

  assign bank = bank_of(addr, mode);
  assign row  = row_of(addr);
endmodule

// File: rtl/bcd_row_dedup.sv
module bcd_row_dedup #(
  parameter int LANES  = 32,
  parameter int BANK_W = 5,
  parameter int ADDR_W = 16
) (
  input  logic [LANES-1:0]  valid,
  input  logic [BANK_W-1:0] bank [LANES],
  input  logic [ADDR_W-1:0] row  [LANES],
  output logic [LANES-1:0]  first,
  output logic              clash
);
  logic [LANES-1:0] seen_before;

  // first[i]: lane i is the lowest active lane asking for its (bank,row)
  // clash: two active lanes share a bank but not a row
  always_comb begin
    seen_before = '0;
    clash       = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      for (int j = 0; j < i; j++) begin
        if (valid[i] && valid[j] && bank[i] == bank[j]) begin
          if (row[i] == row[j]) seen_before[i] = 1'b1;
          else                  clash          = 1'b1;
        end
      end
    end
    first = valid & ~seen_before;
  end
endmodule

// File: rtl/bcd_pass_count.sv
module bcd_pass_count #(
  parameter int LANES  = 32,
  parameter int BANK_W = 5,
  parameter int CNT_W  = 6
) (
  input  logic [LANES-1:0]  first,
  input  logic [BANK_W-1:0] bank [LANES],
  output logic [CNT_W-1:0]  passes
);
  logic [CNT_W-1:0] tally;

  // Each distinct row owner counts the distinct rows in its own bank; keep the maximum
  always_comb begin
    passes = '0;
    tally  = '0;
    for (int i = 0; i < LANES; i++) begin
      tally = '0;
      for (int j = 0; j < LANES; j++) begin
        if (first[j] && bank[j] == bank[i]) tally = tally + CNT_W'(1);
      end
      if (first[i] && tally > passes) passes = tally;
    end
  end
endmodule

// File: rtl/bank_conflict_detect.sv
module bank_conflict_detect #(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int ADDR_W = 16,
  localparam int BANK_W = $clog2(BANKS),
  localparam int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req,
  input  logic                      mode,
  input  logic [LANES-1:0]          lane_valid,
  input  logic [LANES*ADDR_W-1:0]   lane_addr,
  output logic                      done,
  output logic                      conflict,
  output logic [CNT_W-1:0]          passes,
  output logic [LANES*BANK_W-1:0]   bank_idx
);
  import bcd_pkg::*;

  interleave_e       mode_e;
  logic [BANK_W-1:0] lane_bank [LANES];
  logic [ADDR_W-1:0] lane_row  [LANES];
  logic [LANES*BANK_W-1:0] bank_flat;

  // Named internal events for the checks below
  logic              capture_evt;
  logic [LANES-1:0]  first_hit;
  logic              pair_clash;
  logic [CNT_W-1:0]  pass_calc;

  assign mode_e      = interleave_e'(mode);
  assign capture_evt = req;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bcd_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_map (
      .addr (lane_addr[g*ADDR_W +: ADDR_W]),
      .mode (mode_e),
      .bank (lane_bank[g]),
      .row  (lane_row[g])
    );
    assign bank_flat[g*BANK_W +: BANK_W] = lane_bank[g];
  end

  bcd_row_dedup #(.LANES(LANES), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_dedup (
    .valid (lane_valid),
    .bank  (lane_bank),
    .row   (lane_row),
    .first (first_hit),
    .clash (pair_clash)
  );

  bcd_pass_count #(.LANES(LANES), .BANK_W(BANK_W), .CNT_W(CNT_W)) u_count (
    .first  (first_hit),
    .bank   (lane_bank),
    .passes (pass_calc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      conflict <= 1'b0;
      passes   <= '0;
      bank_idx <= '0;
    end else begin
      done <= capture_evt;
      if (capture_evt) begin
        conflict <= pair_clash;
        passes   <= pass_calc;
        bank_idx <= bank_flat;
      end
    end
  end

  // R8: a strobe is answered on the very next edge
  a_r8_done_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> done);

  // R8: no done without a strobe one cycle earlier
  a_r8_done_needs_req: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req));

  // R8: results hold while no strobe arrives
  a_r8_hold_results: assert property (@(posedge clk) disable iff (rst)
    (!req && !rst) |=> ($stable(passes) && $stable(conflict) && $stable(bank_idx)));

  // R7: pairwise clash detection agrees with the row-count maximum
  a_r7_conflict_vs_passes: assert property (@(posedge clk) disable iff (rst)
    done |-> (conflict == (passes > CNT_W'(1))));

  // R7: zero passes exactly when the captured group had no active lane
  a_r7_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> ((passes == '0) == ($past(lane_valid) == '0)));

  // R5: passes never exceed the number of active lanes
  a_r5_passes_bounded: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(passes) <= $countones($past(lane_valid))));
endmodule

// File: tb/bank_conflict_detect_tb_top.sv
`timescale 1ns/1ps
module bank_conflict_detect_tb_top;
  localparam int LANES  = 32;
  localparam int ADDR_W = 16;
  localparam int BANK_W = 5;
  localparam int CNT_W  = 6;
  localparam int NV     = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic mode = 1'b0;
  logic [LANES-1:0]        lane_valid = '0;
  logic [LANES*ADDR_W-1:0] lane_addr  = '0;
  logic                    done;
  logic                    conflict;
  logic [CNT_W-1:0]        passes;
  logic [LANES*BANK_W-1:0] bank_idx;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] addr_q [LANES];

  always #2.5 clk = ~clk;

  bank_conflict_detect dut_i (
    .clk(clk), .rst(rst), .req(req), .mode(mode),
    .lane_valid(lane_valid), .lane_addr(lane_addr),
    .done(done), .conflict(conflict), .passes(passes), .bank_idx(bank_idx)
  );

  // {mode, base, stride, valid mask, expected passes}
  localparam logic [70:0] VEC [NV] = '{
    {1'b0, 16'd0,  16'd1,  32'hFFFF_FFFF, 6'd1},   // R1 linear words
    {1'b1, 16'd0,  16'd2,  32'hFFFF_FFFF, 6'd1},   // R3 consecutive 64-bit elements
    {1'b0, 16'd0,  16'd2,  32'hFFFF_FFFF, 6'd1},   // R4 i and i+32 inside one segment
    {1'b0, 16'd32, 16'd2,  32'hFFFF_FFFF, 6'd2},   // R4 unaligned run crosses a segment
    {1'b1, 16'd32, 16'd2,  32'hFFFF_FFFF, 6'd1},   // R3 same run in word-64 mode
    {1'b1, 16'd0,  16'd1,  32'hFFFF_FFFF, 6'd1},   // R6 pairs share one 64-bit word
    {1'b1, 16'd0,  16'd64, 32'hFFFF_FFFF, 6'd32},  // R3 all lanes in bank 0
    {1'b0, 16'd0,  16'd64, 32'hFFFF_FFFF, 6'd32},  // R4 all lanes in bank 0
    {1'b0, 16'd5,  16'd0,  32'hFFFF_FFFF, 6'd1},   // R6 full broadcast
    {1'b0, 16'd0,  16'd64, 32'h0000_0000, 6'd0},   // R7 no active lane
    {1'b1, 16'd0,  16'd64, 32'h0000_000F, 6'd4},   // R5 only four lanes count
    {1'b0, 16'd0,  16'd32, 32'hFFFF_FFFF, 6'd16},  // R7 two words per segment
    {1'b1, 16'd0,  16'd32, 32'hFFFF_FFFF, 6'd16},  // R2 banks 0 and 16 only
    {1'b0, 16'd0,  16'd64, 32'h0000_0001, 6'd1}    // R7 single active lane
  };

  function automatic int exp_bank(input int a, input logic m);
    return m ? ((a / 2) % 32) : (a % 32);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pack_addr();
    for (int l = 0; l < LANES; l++) lane_addr[l*ADDR_W +: ADDR_W] = addr_q[l];
  endtask

  // Strobe at a falling edge, sample at the next falling edge (after the capture edge)
  task automatic fire();
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic check_result(input string tag, input int exp_p);
    int bad;
    bad = 0;
    check(done == 1'b1, {tag, " R8 done"}, int'(done), 1);
    check(int'(passes) == exp_p, {tag, " R7 passes"}, int'(passes), exp_p);
    check(conflict == (exp_p > 1), {tag, " R3/R4 conflict"}, int'(conflict), int'(exp_p > 1));
    for (int l = 0; l < LANES; l++)
      if (int'(bank_idx[l*BANK_W +: BANK_W]) != exp_bank(int'(addr_q[l]), mode)) bad++;
    check(bad == 0, mode ? {tag, " R2 banks"} : {tag, " R1 banks"}, bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(done == 1'b0 && conflict == 1'b0, "R9 reset flags", int'({done, conflict}), 0);
    check(passes == '0 && bank_idx == '0, "R9 reset data", int'(passes), 0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      mode       = VEC[v][70];
      lane_valid = VEC[v][37:6];
      for (int l = 0; l < LANES; l++)
        addr_q[l] = ADDR_W'(int'(VEC[v][69:54]) + l * int'(VEC[v][53:38]));
      pack_addr();
      fire();
      check_result($sformatf("vec%0d", v), int'(VEC[v][5:0]));
    end

    // R8: done drops after one cycle, results hold while inputs change without a strobe
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", int'(done), 0);
    mode = 1'b1;
    lane_valid = '1;
    for (int l = 0; l < LANES; l++) addr_q[l] = ADDR_W'(l * 64);
    pack_addr();
    repeat (3) @(negedge clk);
    check(passes == 6'd1 && conflict == 1'b0, "R8 hold passes", int'(passes), 1);
    check(bank_idx[BANK_W +: BANK_W] == 5'd0 && done == 1'b0, "R8 hold banks",
          int'(bank_idx[BANK_W +: BANK_W]), 0);

    // R5/R6: broadcast in bank 0, one extra row (lane 5), one masked lane with a third row
    mode = 1'b0;
    for (int l = 0; l < LANES; l++) addr_q[l] = 16'd0;
    addr_q[5] = 16'd64;
    addr_q[9] = 16'd128;
    lane_valid = '1;
    lane_valid[9] = 1'b0;
    pack_addr();
    fire();
    check_result("mixed R5 R6", 2);

    // R5: the masked lane alone, with the broadcast, leaves one pass
    addr_q[5] = 16'd32;
    pack_addr();
    fire();
    check_result("masked R5", 1);

    // R9: reset after a busy group clears everything
    mode = 1'b0;
    lane_valid = '1;
    for (int l = 0; l < LANES; l++) addr_q[l] = ADDR_W'(l * 64 + 3);
    pack_addr();
    fire();
    check_result("pre-reset", 32);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(passes == '0 && conflict == 1'b0, "R9 clear results", int'(passes), 0);
    check(bank_idx == '0 && done == 1'b0, "R9 clear banks", int'(bank_idx[4:0]), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule